// File: doc/BRIEF.md
# Striped Bank Write Distributor

This block sits between one shared network port and a group of local SRAM banks that together act as a single logical memory. A transfer is announced by a descriptor carrying a placement mode, a starting offset and a word count. The burst that follows arrives one word at a time on a valid/ready stream. The block writes each word into exactly one bank, on that bank's own write port.

Two placements are supported, chosen per transfer. In concatenated placement the banks form one continuous address range: bank 0 rows first, then bank 1, and so on. In interleaved placement consecutive words rotate across the banks, so a row-major stream ends up as column slices in the banks. A descriptor whose range does not fit in the group is refused with a one-cycle error pulse. A completed transfer ends with a one-cycle done pulse.

Top module: `stripe_wr_dist`

## Requirements
- R1: During and right after reset, no bank write enable is high, `done_o` and `err_o` are low, `desc_ready_o` is high and `word_ready_o` is low.
- R2: `desc_ready_o` is high exactly when no transfer is active, and `word_ready_o` is high exactly when one is active. A descriptor offered while a transfer is active is ignored.
- R3: With `desc_mode_i` = 1 (interleaved), word i of the transfer, counting from 0, goes to bank i mod N at row offset + i div N.
- R4: With `desc_mode_i` = 0 (concatenated), word i goes to bank (offset+i) div D at row (offset+i) mod D, where D is the bank depth.
- R5: A word accepted in cycle t shows up as a write in cycle t+1. In that cycle exactly one bank enable is high, and that bank's address and data outputs carry the word's row and value. A cycle with no accepted word has no write.
- R6: Words offered while `word_ready_o` is low are neither written nor counted.
- R7: `done_o` is high for exactly one cycle, the cycle after the write of the transfer's last word.
- R8: A descriptor is refused when its count is 0, or when its range overflows the group. For concatenated placement that means offset+count > N·D. For interleaved placement it means offset·N+count > N·D. A refused descriptor gives `err_o` high for one cycle, in the cycle after the offer, and no transfer starts.
- R9: Gaps in `word_valid_i` during a transfer neither skip nor repeat a position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Idle, a descriptor can be taken |
| desc_mode_i | input | 1 | 0 concatenated, 1 interleaved |
| desc_offset_i | input | OFF_W | Starting offset (logical in concatenated, row in interleaved) |
| desc_count_i | input | CNT_W | Number of words in the transfer |
| word_valid_i | input | 1 | Word offered |
| word_ready_o | output | 1 | Transfer active, word accepted when valid |
| word_data_i | input | DATA_W | Word value |
| bank_we_o | output | NUM_BANKS | Per-bank write enable |
| bank_addr_o | output | NUM_BANKS*AW | Per-bank row address, bank 0 in the low slice |
| bank_data_o | output | NUM_BANKS*DATA_W | Per-bank write data, bank 0 in the low slice |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Descriptor refused pulse |

## Verification
The bench builds the block with three banks of five rows, which are neither powers of two nor equal. With these values, concatenated bursts cross bank boundaries at odd rows, and interleaved bursts wrap the bank index mid-row. The whole group holds only fifteen words, so exact-fit and one-over-capacity descriptors in both modes can be reached with short bursts. A behavioural model that computes bank and row from the word index is compared against every output on every cycle.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  typedef enum logic {
    PLACE_CONCAT     = 1'b0,
    PLACE_INTERLEAVE = 1'b1
  } place_mode_e;
endpackage

// File: rtl/stripe_desc_check.sv
module stripe_desc_check
  import stripe_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 16,
  parameter int OFF_W      = 6,
  parameter int CNT_W      = 7
) (
  input  place_mode_e      mode_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             ok_o
);
  localparam int TOTAL = NUM_BANKS * BANK_DEPTH;
  localparam int EXT_W = OFF_W + CNT_W + $clog2(NUM_BANKS + 1) + 2;

  logic [EXT_W-1:0] off_ext, cnt_ext, span_end;

  always_comb begin
    off_ext = EXT_W'(offset_i);
    cnt_ext = EXT_W'(count_i);
    if (mode_i == PLACE_INTERLEAVE) span_end = off_ext * EXT_W'(NUM_BANKS) + cnt_ext;
    else                            span_end = off_ext + cnt_ext;
    ok_o = (count_i != '0) && (span_end <= EXT_W'(TOTAL));
  end
endmodule

// File: rtl/stripe_cursor.sv
module stripe_cursor
  import stripe_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 16,
  parameter int BSEL_W     = 2,
  parameter int AW         = 4,
  parameter int OFF_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  place_mode_e       mode_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              step_i,
  output logic [BSEL_W-1:0] bank_o,
  output logic [AW-1:0]     row_o
);
  place_mode_e       mode_q;
  logic [BSEL_W-1:0] bank_q, start_bank;
  logic [AW-1:0]     row_q, start_row;
  logic [31:0]       off_w;

  always_comb begin
    off_w = 32'(offset_i);
    if (mode_i == PLACE_INTERLEAVE) begin
      start_bank = '0;
      start_row  = AW'(off_w);
    end else begin
      start_bank = BSEL_W'(off_w / BANK_DEPTH);
      start_row  = AW'(off_w % BANK_DEPTH);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PLACE_CONCAT;
      bank_q <= '0;
      row_q  <= '0;
    end else if (load_i) begin
      mode_q <= mode_i;
      bank_q <= start_bank;
      row_q  <= start_row;
    end else if (step_i) begin
      if (mode_q == PLACE_INTERLEAVE) begin
        // rotate banks first, next row after the last bank
        if (bank_q == BSEL_W'(NUM_BANKS - 1)) begin
          bank_q <= '0;
          row_q  <= row_q + 1'b1;
        end else begin
          bank_q <= bank_q + 1'b1;
        end
      end else begin
        // fill a bank to its last row, then move on
        if (row_q == AW'(BANK_DEPTH - 1)) begin
          row_q  <= '0;
          bank_q <= bank_q + 1'b1;
        end else begin
          row_q  <= row_q + 1'b1;
        end
      end
    end
  end

  assign bank_o = bank_q;
  assign row_o  = row_q;
endmodule

// File: rtl/stripe_bank_port.sv
module stripe_bank_port #(
  parameter int NUM_BANKS = 4,
  parameter int BSEL_W    = 2,
  parameter int AW        = 4,
  parameter int DATA_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fire_i,
  input  logic [BSEL_W-1:0]           sel_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic [NUM_BANKS-1:0]        we_o,
  output logic [NUM_BANKS*AW-1:0]     addr_o,
  output logic [NUM_BANKS*DATA_W-1:0] data_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              we_q, hit;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] data_q;

    assign hit = fire_i && (sel_i == BSEL_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        we_q   <= 1'b0;
        addr_q <= '0;
        data_q <= '0;
      end else begin
        we_q <= hit;
        if (hit) begin
          addr_q <= addr_i;
          data_q <= data_i;
        end
      end
    end

    assign we_o[b]                     = we_q;
    assign addr_o[b*AW +: AW]          = addr_q;
    assign data_o[b*DATA_W +: DATA_W]  = data_q;
  end
endmodule

// File: rtl/stripe_wr_dist.sv
module stripe_wr_dist
  import stripe_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 16,
  parameter int DATA_W     = 32,
  localparam int TOTAL     = NUM_BANKS * BANK_DEPTH,
  localparam int OFF_W     = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int CNT_W     = $clog2(TOTAL + 1),
  localparam int AW        = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1,
  localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        desc_valid_i,
  output logic                        desc_ready_o,
  input  logic                        desc_mode_i,
  input  logic [OFF_W-1:0]            desc_offset_i,
  input  logic [CNT_W-1:0]            desc_count_i,
  input  logic                        word_valid_i,
  output logic                        word_ready_o,
  input  logic [DATA_W-1:0]           word_data_i,
  output logic [NUM_BANKS-1:0]        bank_we_o,
  output logic [NUM_BANKS*AW-1:0]     bank_addr_o,
  output logic [NUM_BANKS*DATA_W-1:0] bank_data_o,
  output logic                        done_o,
  output logic                        err_o
);
  place_mode_e       mode_in;
  logic              desc_ok, desc_hs, word_hs;
  logic              busy_q, last_wr_q, done_q, err_q;
  logic [CNT_W-1:0]  remain_q;
  logic [BSEL_W-1:0] cur_bank;
  logic [AW-1:0]     cur_row;

  assign mode_in = place_mode_e'(desc_mode_i);
  assign desc_hs = desc_valid_i && !busy_q;
  assign word_hs = word_valid_i && busy_q;

  stripe_desc_check #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_DEPTH(BANK_DEPTH),
    .OFF_W     (OFF_W),
    .CNT_W     (CNT_W)
  ) u_check (
    .mode_i  (mode_in),
    .offset_i(desc_offset_i),
    .count_i (desc_count_i),
    .ok_o    (desc_ok)
  );

  stripe_cursor #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_DEPTH(BANK_DEPTH),
    .BSEL_W    (BSEL_W),
    .AW        (AW),
    .OFF_W     (OFF_W)
  ) u_cursor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (desc_hs && desc_ok),
    .mode_i  (mode_in),
    .offset_i(desc_offset_i),
    .step_i  (word_hs),
    .bank_o  (cur_bank),
    .row_o   (cur_row)
  );

  stripe_bank_port #(
    .NUM_BANKS(NUM_BANKS),
    .BSEL_W   (BSEL_W),
    .AW       (AW),
    .DATA_W   (DATA_W)
  ) u_ports (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(word_hs),
    .sel_i (cur_bank),
    .addr_i(cur_row),
    .data_i(word_data_i),
    .we_o  (bank_we_o),
    .addr_o(bank_addr_o),
    .data_o(bank_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      remain_q  <= '0;
      last_wr_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      last_wr_q <= word_hs && (remain_q == CNT_W'(1));
      done_q    <= last_wr_q;
      err_q     <= desc_hs && !desc_ok;
      if (desc_hs && desc_ok) begin
        busy_q   <= 1'b1;
        remain_q <= desc_count_i;
      end else if (word_hs) begin
        remain_q <= remain_q - 1'b1;
        if (remain_q == CNT_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign desc_ready_o = !busy_q;
  assign word_ready_o = busy_q;
  assign done_o       = done_q;
  assign err_o        = err_q;

  // R5
  we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we_o));
  // R5
  wr_follows_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o) |=> ($countones(bank_we_o) == 1));
  // R6
  no_stray_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_i && word_ready_o) |=> (bank_we_o == '0));
  // R7
  done_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(|bank_we_o));
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  err_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (desc_ready_o && !word_ready_o));
  // R2
  busy_ignores_desc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_ready_o && !(word_valid_i && remain_q == CNT_W'(1))) |=> word_ready_o);
endmodule

// File: tb/sim_stripe_wr_dist.sv
`timescale 1ns/1ps
module sim_stripe_wr_dist;
  localparam int N   = 3;
  localparam int D   = 5;
  localparam int DW  = 16;
  localparam int TOT = N * D;
  localparam int OW  = $clog2(TOT);
  localparam int CW  = $clog2(TOT + 1);
  localparam int AW  = $clog2(D);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic desc_valid = 1'b0, desc_mode = 1'b0, word_valid = 1'b0;
  logic [OW-1:0] desc_off = '0;
  logic [CW-1:0] desc_cnt = '0;
  logic [DW-1:0] word_data = '0;
  logic desc_ready, word_ready, done, err;
  logic [N-1:0]    we;
  logic [N*AW-1:0] addr;
  logic [N*DW-1:0] data;

  always #2.5 clk = ~clk;

  stripe_wr_dist #(.NUM_BANKS(N), .BANK_DEPTH(D), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .desc_valid_i(desc_valid), .desc_ready_o(desc_ready), .desc_mode_i(desc_mode),
    .desc_offset_i(desc_off), .desc_count_i(desc_cnt),
    .word_valid_i(word_valid), .word_ready_o(word_ready), .word_data_i(word_data),
    .bank_we_o(we), .bank_addr_o(addr), .bank_data_o(data),
    .done_o(done), .err_o(err));

  int total = 0, bad = 0, cyc = 0;
  string cur_tag = "R1";
  bit run_cmp = 0;

  // reference model state
  bit m_idle = 1, m_mode = 0, pend_done = 0;
  int m_off = 0, m_cnt = 0, m_idx = 0;
  bit exp_we_v = 0, exp_done = 0, exp_err = 0;
  int exp_bank = 0, exp_row = 0, exp_data = 0;
  logic [DW-1:0] seq = 16'h1000;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      logic [N-1:0] ew;
      ew = exp_we_v ? (N'(1) << exp_bank) : '0;
      chk(we == ew, "R5 bank_we", we, ew);
      if (exp_we_v) begin
        chk(addr[exp_bank*AW +: AW] == AW'(exp_row), "R3/R4 row", addr[exp_bank*AW +: AW], exp_row);
        chk(data[exp_bank*DW +: DW] == DW'(exp_data), "R5 data", data[exp_bank*DW +: DW], exp_data);
      end
      chk(done == exp_done, "R7 done", done, exp_done);
      chk(err == exp_err, "R8 err", err, exp_err);
      chk(desc_ready == m_idle, "R2 desc_ready", desc_ready, m_idle);
      chk(word_ready == !m_idle, "R2 word_ready", word_ready, !m_idle);
      // expectations for the next cycle
      exp_done  = pend_done;
      pend_done = 0;
      exp_we_v  = 0;
      exp_err   = 0;
      if (!m_idle && word_valid) begin
        if (m_mode) begin
          exp_bank = m_idx % N;
          exp_row  = m_off + m_idx / N;
        end else begin
          exp_bank = (m_off + m_idx) / D;
          exp_row  = (m_off + m_idx) % D;
        end
        exp_we_v = 1;
        exp_data = int'(word_data);
        m_idx++;
        if (m_idx == m_cnt) begin
          m_idle    = 1;
          pend_done = 1;
        end
      end else if (m_idle && desc_valid) begin
        int span;
        span = desc_mode ? int'(desc_off) * N + int'(desc_cnt) : int'(desc_off) + int'(desc_cnt);
        if (desc_cnt != 0 && span <= TOT) begin
          m_idle = 0;
          m_mode = desc_mode;
          m_off  = int'(desc_off);
          m_cnt  = int'(desc_cnt);
          m_idx  = 0;
        end else begin
          exp_err = 1;
        end
      end
    end
  end

  task automatic send_desc(input bit mode, input int off, input int cnt);
    desc_valid = 1; desc_mode = mode; desc_off = OW'(off); desc_cnt = CW'(cnt);
    @(posedge clk); #1;
    desc_valid = 0;
  endtask

  task automatic send_words(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      bit taken;
      word_valid = 1;
      word_data  = seq;
      taken = 0;
      while (!taken) begin
        @(negedge clk);
        taken = word_ready;
        @(posedge clk); #1;
      end
      seq = seq + 16'h0107;
      word_valid = 0;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
      end
    end
    word_valid = 0;
  endtask

  task automatic idle_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    idle_cycles(2);
    @(negedge clk);
    // R1 values held in reset
    chk(we == '0, "R1 we", we, 0);
    chk(done == 0 && err == 0, "R1 pulses", {done, err}, 0);
    chk(desc_ready == 1, "R1 desc_ready", desc_ready, 1);
    chk(word_ready == 0, "R1 word_ready", word_ready, 0);
    @(posedge clk); #1;
    rst_ni = 1;
    run_cmp = 1;
    idle_cycles(2);

    cur_tag = "R4";   // concatenated, crosses two bank boundaries
    send_desc(0, 2, 9);
    send_words(9, 0);
    idle_cycles(3);

    cur_tag = "R3";   // interleaved, starting row 1
    send_desc(1, 1, 10);
    send_words(10, 0);
    idle_cycles(3);

    cur_tag = "R9";   // gaps between words
    send_desc(1, 0, 7);
    send_words(7, 2);
    idle_cycles(3);
    send_desc(0, 7, 5);
    send_words(5, 1);
    idle_cycles(3);

    cur_tag = "R2";   // descriptor offered while busy
    send_desc(0, 0, 4);
    send_desc(1, 3, 2);
    send_words(4, 0);
    idle_cycles(3);

    cur_tag = "R6";   // words while idle
    word_valid = 1; word_data = 16'hdead;
    idle_cycles(3);
    word_valid = 0;
    idle_cycles(2);

    cur_tag = "R8";   // refusals and exact fits
    send_desc(0, 10, 6);
    idle_cycles(2);
    send_desc(1, 4, 4);
    idle_cycles(2);
    send_desc(0, 3, 0);
    idle_cycles(2);
    send_desc(1, 4, 3);
    send_words(3, 0);
    idle_cycles(3);
    send_desc(0, 0, 15);
    send_words(15, 0);
    idle_cycles(3);

    cur_tag = "R7";   // back-to-back transfers, done overlaps next descriptor
    send_desc(0, 14, 1);
    send_words(1, 0);
    send_desc(1, 2, 3);
    send_words(3, 0);
    idle_cycles(4);

    summary();
  end
endmodule